// File: doc/BRIEF.md
# Music Player Interrupt Timer

This block gives a small CPU that plays music the interrupt it needs. It sits on an 8-bit data bus with a 16-bit address and separate read and write strobes. It drives one active-low interrupt line. The CPU's interrupt handler reads a status byte that says why it was called: to start a tune (init), to halt it (stop), or to run the next periodic step of the tune (play). Reading that status byte also withdraws the interrupt.

Software writes a 16-bit reload value as two bytes. It then writes a nonzero byte to the status address to start the timer. A watchdog holds off the first play interrupt for four frames. Software can write to a separate address to shorten that wait to one frame. After the first play interrupt, the interrupt repeats every reload+1 CPU cycles. The host side of the player raises init and stop requests through two single-cycle inputs. A read-only byte reports, through a parameter, which extra sound hardware the player has.

Top module: `mpit_top`

## Requirements
- R1: After reset, irqN is high, the timer is stopped, and a read of 0x3E12 returns 0 (init). No interrupt occurs until the timer is started or a request arrives.
- R2: A write to 0x3E10 sets bits 7:0 of the 16-bit reload value. A write to 0x3E11 sets bits 15:8.
- R3: A write of a nonzero byte to 0x3E12 starts the timer. Unless 0x3E13 is written afterwards, the first play interrupt goes low exactly 4*FRAME_CYCLES cycles after the clock edge that takes that write.
- R4: A write to 0x3E13 while the timer runs reschedules the next play interrupt. The interrupt then comes exactly FRAME_CYCLES cycles after the clock edge that takes that write.
- R5: Once a play interrupt has fired, the next play interrupt fires reload+1 cycles later. With reload 0, an interrupt fires on every cycle. Each play interrupt sets the cause code to 2.
- R6: A read of 0x3E12 returns the cause code in bits 1:0 (0 init, 1 stop, 2 play), with bits 7:2 zero. On the next clock edge the read withdraws the pending interrupt (irqN high), unless a new interrupt event happens on that same edge.
- R7: A write of 0 to 0x3E12 stops the timer and withdraws any pending interrupt. No play interrupt follows.
- R8: A pulse on stopReq sets the cause to 1 and pulls irqN low. A pulse on initReq sets the cause to 0 and pulls irqN low. A request takes priority over a play tick on the same edge, and initReq takes priority over stopReq.
- R9: A read of 0x3E13 returns the CHIP_FLAGS parameter in bits 5:0, with the upper bits zero. Reads of any address other than 0x3E12 and 0x3E13 return 0.
- R10: irqN is a level output. Once low, it stays low until a read of 0x3E12 or a write of 0 to 0x3E12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; the timer counts its rising edges |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| rdData | output | 8 | Read data, valid combinationally while rdEn is high |
| initReq | input | 1 | One-cycle request for an init interrupt |
| stopReq | input | 1 | One-cycle request for a stop interrupt |
| irqN | output | 1 | Active-low level interrupt |

## Verification
Some rules are checked on every cycle:
- irqN falls only after a tick or a request.
- A status read or a zero enable write raises irqN, unless a new event happens on the same edge.
- A pending interrupt holds until one of those two accesses.
- Each event leaves the matching cause code behind.

The exact delays cannot be seen in a one-cycle property and are left to the bench scenarios:
- the four-frame watchdog and its one-frame shortcut;
- the reload+1 period across a sweep of reload values;
- byte placement in the reload register;
- the flag byte read back.

// File: rtl/mpit_pkg.sv
package mpit_pkg;

  localparam logic [15:0] ADDR_RELOAD_LO = 16'h3E10;
  localparam logic [15:0] ADDR_RELOAD_HI = 16'h3E11;
  localparam logic [15:0] ADDR_STATUS    = 16'h3E12;
  localparam logic [15:0] ADDR_KICK      = 16'h3E13;

  typedef enum logic [1:0] {
    CAUSE_INIT = 2'd0,
    CAUSE_STOP = 2'd1,
    CAUSE_PLAY = 2'd2
  } cause_t;

  // Strobes decoded from one bus cycle, handed from control to datapath
  typedef struct packed {
    logic loadLo;   // write reload bits 7:0
    logic loadHi;   // write reload bits 15:8
    logic setRun;   // write to the status/enable address
    logic runVal;   // value written there is nonzero
    logic kick;     // watchdog shortcut write
    logic ackRead;  // status read, withdraws pending interrupt
  } busStrobe_t;

endpackage

// File: rtl/mpit_bus_ctrl.sv
module mpit_bus_ctrl
  import mpit_pkg::*;
#(
  parameter int          FLAGS_W    = 6,
  parameter logic [FLAGS_W-1:0] CHIP_FLAGS = '0
) (
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  input  cause_t      causeCode,
  output busStrobe_t  strobe,
  output logic [7:0]  rdData
);

  localparam int PAD_W = 8 - FLAGS_W;

  logic hitLo, hitHi, hitStatus, hitKick;

  always_comb begin
    hitLo     = (addr == ADDR_RELOAD_LO);
    hitHi     = (addr == ADDR_RELOAD_HI);
    hitStatus = (addr == ADDR_STATUS);
    hitKick   = (addr == ADDR_KICK);
  end

  always_comb begin
    strobe         = '0;
    strobe.loadLo  = wrEn && hitLo;
    strobe.loadHi  = wrEn && hitHi;
    strobe.setRun  = wrEn && hitStatus;
    strobe.runVal  = |wrData;
    strobe.kick    = wrEn && hitKick;
    strobe.ackRead = rdEn && hitStatus;
  end

  always_comb begin
    rdData = 8'h00;
    if (rdEn) begin
      if (hitStatus)    rdData = {6'b0, causeCode};
      else if (hitKick) rdData = {{PAD_W{1'b0}}, CHIP_FLAGS};
    end
  end

endmodule

// File: rtl/mpit_timer_core.sv
module mpit_timer_core
  import mpit_pkg::*;
#(
  parameter int FRAME_CYCLES = 29780,
  parameter int WD_FRAMES    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t strobe,
  input  logic [7:0] wrData,
  input  logic       initReq,
  input  logic       stopReq,
  output cause_t     causeCode,
  output logic       irqPending,
  output logic       running,
  output logic       tickNow
);

  localparam int WD_CYCLES = WD_FRAMES * FRAME_CYCLES;
  localparam int WD_BITS   = $clog2(WD_CYCLES + 1);
  localparam int CNT_W     = (WD_BITS > 16) ? WD_BITS : 16;
  localparam logic [CNT_W-1:0] WD_START    = CNT_W'(WD_CYCLES - 1);
  localparam logic [CNT_W-1:0] FRAME_START = CNT_W'(FRAME_CYCLES - 1);

  logic [15:0]      reloadVal;
  logic [CNT_W-1:0] cnt;
  logic             stopWrite;

  // A tick is lost to a same-edge enable or kick write
  assign tickNow   = running && (cnt == '0) && !strobe.setRun && !strobe.kick;
  assign stopWrite = strobe.setRun && !strobe.runVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else begin
      if (strobe.loadLo) reloadVal[7:0]  <= wrData;
      if (strobe.loadHi) reloadVal[15:8] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (strobe.setRun) begin
      running <= strobe.runVal;
      cnt     <= WD_START;
    end else if (running) begin
      if (strobe.kick)  cnt <= FRAME_START;
      else if (tickNow) cnt <= CNT_W'(reloadVal);
      else              cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      causeCode  <= CAUSE_INIT;
    end else if (initReq) begin
      irqPending <= 1'b1;
      causeCode  <= CAUSE_INIT;
    end else if (stopReq) begin
      irqPending <= 1'b1;
      causeCode  <= CAUSE_STOP;
    end else if (stopWrite) begin
      irqPending <= 1'b0;
    end else if (tickNow) begin
      irqPending <= 1'b1;
      causeCode  <= CAUSE_PLAY;
    end else if (strobe.ackRead) begin
      irqPending <= 1'b0;
    end
  end

endmodule

// File: rtl/mpit_top.sv
module mpit_top
  import mpit_pkg::*;
#(
  parameter int FRAME_CYCLES = 29780,
  parameter int FLAGS_W      = 6,
  parameter logic [FLAGS_W-1:0] CHIP_FLAGS = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  output logic [7:0]  rdData,
  input  logic        initReq,
  input  logic        stopReq,
  output logic        irqN
);

  busStrobe_t strobe;
  cause_t     causeCode;
  logic       irqPending;
  logic       running;
  logic       tickNow;

  mpit_bus_ctrl #(
    .FLAGS_W   (FLAGS_W),
    .CHIP_FLAGS(CHIP_FLAGS)
  ) uCtrl (
    .addr     (addr),
    .wrData   (wrData),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .causeCode(causeCode),
    .strobe   (strobe),
    .rdData   (rdData)
  );

  mpit_timer_core #(
    .FRAME_CYCLES(FRAME_CYCLES)
  ) uCore (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .initReq   (initReq),
    .stopReq   (stopReq),
    .causeCode (causeCode),
    .irqPending(irqPending),
    .running   (running),
    .tickNow   (tickNow)
  );

  assign irqN = !irqPending;

endmodule

// File: rtl/mpit_checker.sv
module mpit_checker
  import mpit_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic [7:0]  wrData,
  input logic        wrEn,
  input logic        rdEn,
  input logic        initReq,
  input logic        stopReq,
  input logic        irqN,
  input logic        tickNow,
  input logic        running,
  input cause_t      causeCode
);

  logic statusRead, stopWrite, anyReq;
  assign statusRead = rdEn && (addr == ADDR_STATUS);
  assign stopWrite  = wrEn && (addr == ADDR_STATUS) && (wrData == 8'h00);
  assign anyReq     = initReq || stopReq;

  // R3: the line falls only after a tick or a request
  p_no_spurious_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(tickNow || anyReq));

  // R5: a play tick leaves the play cause and a pending interrupt
  p_play_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickNow && !anyReq) |=> (!irqN && causeCode == CAUSE_PLAY));

  // R6: a status read withdraws the interrupt
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !anyReq && !tickNow) |=> irqN);

  // R7: a zero enable write stops the timer and withdraws the interrupt
  p_disable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopWrite && !anyReq) |=> (irqN && !running));

  // R8: a stop request wins over a same-edge tick
  p_stop_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !initReq) |=> (!irqN && causeCode == CAUSE_STOP));

  // R10: a pending interrupt holds until acknowledged or disabled
  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !statusRead && !stopWrite) |=> !irqN);

endmodule

bind mpit_top mpit_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrData   (wrData),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .initReq  (initReq),
  .stopReq  (stopReq),
  .irqN     (irqN),
  .tickNow  (tickNow),
  .running  (running),
  .causeCode(causeCode)
);

// File: tb/sim_mpit_top.sv
`timescale 1ns/1ps
module sim_mpit_top;

  localparam int FRAME = 10;
  localparam logic [5:0] FLAGS = 6'h2D;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        initReq = 1'b0;
  logic        stopReq = 1'b0;
  logic        irqN;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mpit_top #(.FRAME_CYCLES(FRAME), .FLAGS_W(6), .CHIP_FLAGS(FLAGS)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .initReq(initReq), .stopReq(stopReq),
    .irqN(irqN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseReq(input bit isStop);
    if (isStop) stopReq = 1'b1; else initReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0; initReq = 1'b0;
  endtask

  // m counts edges since a reference edge; the current negedge follows edge m
  task automatic waitIrq(input int start, output int m);
    m = start;
    while (irqN && m < 2000) begin
      @(negedge clk);
      m++;
    end
  endtask

  task automatic idleCountLow(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!irqN) lows++;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int m, lows;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irqN == 1'b1, "R1 irqN after reset", irqN, 1);
    busRead(16'h3E12, d);
    chk(d == 8'h00, "R1 cause after reset", d, 0);
    idleCountLow(60, lows);
    chk(lows == 0, "R1 no interrupt while idle", lows, 0);

    // R9 flag byte and unmapped reads
    busRead(16'h3E13, d);
    chk(d == {2'b00, FLAGS}, "R9 flag byte", d, FLAGS);
    busRead(16'h3E14, d);
    chk(d == 8'h00, "R9 unmapped read", d, 0);
    busRead(16'h3E10, d);
    chk(d == 8'h00, "R9 reload address reads zero", d, 0);

    // R3 R5 R6 R7 sweep of small reload values
    for (int r = 0; r <= 12; r++) begin
      busWrite(16'h3E10, 8'(r));
      busWrite(16'h3E11, 8'h00);
      busWrite(16'h3E12, (r == 5) ? 8'h80 : 8'(r + 1));
      waitIrq(0, m);
      chk(m == 4 * FRAME, "R3 first play after four frames", m, 4 * FRAME);
      for (int k = 0; k < 2; k++) begin
        busRead(16'h3E12, d);
        chk(d == 8'h02, "R6 play cause code", d, 2);
        waitIrq(1, m);
        chk(m == r + 1, "R5 play period reload+1", m, r + 1);
      end
      busWrite(16'h3E12, 8'h00);
      chk(irqN == 1'b1, "R7 disable withdraws interrupt", irqN, 1);
    end
    idleCountLow(60, lows);
    chk(lows == 0, "R7 no play after disable", lows, 0);

    // R2 high byte placement: reload 0x0102 gives period 259
    busWrite(16'h3E10, 8'h02);
    busWrite(16'h3E11, 8'h01);
    busWrite(16'h3E12, 8'h01);
    waitIrq(0, m);
    chk(m == 4 * FRAME, "R3 first play with wide reload", m, 4 * FRAME);
    busRead(16'h3E12, d);
    waitIrq(1, m);
    chk(m == 259, "R2 reload byte placement", m, 259);
    busWrite(16'h3E12, 8'h00);

    // R4 watchdog shortcut
    busWrite(16'h3E10, 8'h07);
    busWrite(16'h3E11, 8'h00);
    busWrite(16'h3E12, 8'h01);
    repeat (5) @(negedge clk);
    busWrite(16'h3E13, 8'h55);
    waitIrq(0, m);
    chk(m == FRAME, "R4 play one frame after kick", m, FRAME);
    busRead(16'h3E12, d);
    waitIrq(1, m);
    chk(m == 8, "R5 period after kick", m, 8);
    busWrite(16'h3E12, 8'h00);

    // R8 R10 requests with the timer stopped
    pulseReq(1'b1);
    chk(irqN == 1'b0, "R8 stop request asserts irq", irqN, 0);
    idleCountLow(15, lows);
    chk(lows == 15, "R10 level held until read", lows, 15);
    busRead(16'h3E12, d);
    chk(d == 8'h01, "R8 stop cause code", d, 1);
    chk(irqN == 1'b1, "R6 read withdraws interrupt", irqN, 1);
    pulseReq(1'b0);
    chk(irqN == 1'b0, "R8 init request asserts irq", irqN, 0);
    busWrite(16'h3E11, 8'h00);
    chk(irqN == 1'b0, "R10 unrelated write keeps irq", irqN, 0);
    busRead(16'h3E12, d);
    chk(d == 8'h00, "R8 init cause code", d, 0);
    chk(irqN == 1'b1, "R6 init acknowledged", irqN, 1);

    // R8 request wins over a same-edge tick (reload 0 ticks every edge)
    busWrite(16'h3E10, 8'h00);
    busWrite(16'h3E12, 8'h01);
    waitIrq(0, m);
    pulseReq(1'b1);
    busRead(16'h3E12, d);
    chk(d == 8'h01, "R8 stop wins over tick", d, 1);
    initReq = 1'b1; stopReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0; stopReq = 1'b0;
    busRead(16'h3E12, d);
    chk(d == 8'h00, "R8 init wins over stop", d, 0);
    busWrite(16'h3E12, 8'h00);
    chk(irqN == 1'b1, "R7 disable at reload zero", irqN, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule